// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings a display panel's supply rails and control signals up and down in a fixed, interlocked order. It emits the order as a series of register writes addressed to a panel timing controller and pauses for the settling times the rails need. The common-electrode bias is not written through that path. It is handed to an external DAC writer over a separate handshake. The serial transport that carries the writes to the controller lies outside this block.

A power-on request from an idle, uninitialized state runs the full start-up programme. It ends with the phase-adjust, polarity and resolution registers and sets an internal initialized flag. A power-on request while that flag is set is a mode change. It rewrites only the phase and resolution registers.

A power-off request first waits two frame times. It then unwinds the rails in the safe order, drives the common bias to zero and clears the flag. Millisecond waits are derived from the system clock through a prescaler whose cycles-per-millisecond is a parameter.

Both outgoing paths are valid/ready streams. While valid is high and ready is low, the address, data or code is held unchanged and the sequence stalls. There is no time limit on that stall. A transfer completes on the clock edge where valid and ready are both high, and exactly one transfer is made per step.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `wr_valid`, `dac_valid`, `busy` and `inited` are all 0.
- R2: Every register write is a valid/ready transfer on `wr_addr`/`wr_data`. While `wr_valid` is high and `wr_ready` is low, the address and data do not change. Address codes are:
  - resolution 0
  - phase 1
  - power-A 3, where bit 2 is DAC, bit 3 is COM, bit 4 is VCC5, and bits 1:0 are the bias clock/data idle levels
  - power-B 4, where bit 0 is the VW switch, bit 1 is the negative gate rail and bit 2 is VDD
  - panel control 6, where bit 0 is init state, bit 1 is init-off, bit 2 is power-down, bit 3 is COM signal off and bit 4 is DAC signal off
  - polarity 7
- R3: A cold power-on issues these transfers, written addr:data in hex, in this order: 6:1F, 3:03, 4:00, 4:04, 3:07, 6:09, then the bias load, then 3:17, 4:06, 6:01, 3:1F, 4:07, 6:00, 1:phase, 7:00, 0:resolution. At the end `inited` is 1.
- R4: After the 4:04 write the block waits 3 ms, after the 4:06 write 2 ms, and after the 7:00 write 1 ms. A wait of N ms means N×`CYC_PER_MS` cycles pass from the accepting edge of that write until the next step is presented. Steps with no wait follow on the next cycle.
- R5: The bias is loaded by a `dac_valid`/`dac_ready` transfer carrying `dac_code`. The code is `vcom_val` when `vcom_vld` is set and 125 otherwise. `dac_valid` and `wr_valid` are never high together, and `dac_code` holds while a DAC transfer is stalled.
- R6: For VGA (`res_qvga`=0), the phase byte is {`phase_val`,1} when `phase_vld` is set and 0x01 otherwise. For QVGA it is always 0x13.
- R7: The resolution byte is 0x01 for QVGA and 0x00 for VGA.
- R8: A power-on while `inited` is 1 issues only 1:phase followed by 0:resolution, with no bias load and no wait.
- R9: A power-off first waits 34 ms. It then issues 4:06, 6:08, 3:14, a bias load of 0, 4:04, 3:10, 6:1E, 3:00, 4:00, and leaves `inited` at 0.
- R10: Requests that arrive while `busy` is 1 are ignored, and the running sequence is unchanged.
- R11: When both requests arrive together on an idle block, power-off is taken.
- R12: Resolution, phase and bias inputs are captured in the request cycle. Later changes do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Power-on / mode-change request, sampled when idle |
| pwr_off_req | input | 1 | Power-off request, sampled when idle |
| res_qvga | input | 1 | 1 selects QVGA, 0 selects VGA |
| phase_val | input | 4 | Phase-adjust value |
| phase_vld | input | 1 | Qualifies `phase_val` |
| vcom_val | input | 8 | Common bias code |
| vcom_vld | input | 1 | Qualifies `vcom_val` |
| wr_valid | output | 1 | Register write presented |
| wr_ready | input | 1 | Controller accepts the write |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| dac_valid | output | 1 | Bias code presented |
| dac_ready | input | 1 | DAC writer accepts the code |
| dac_code | output | 8 | Bias code |
| busy | output | 1 | A sequence is running |
| inited | output | 1 | Panel initialized flag |

## Verification
With both ready inputs held high, consecutive steps without a wait are accepted on adjacent cycles. A step followed by an N ms wait is accepted N×`CYC_PER_MS`+1 cycles before the next one. The bench logs every accepted transfer with its cycle number at the falling edge and checks those exact gaps for the 3, 2 and 1 ms waits. For the 34 ms pre-wait of power-off, it checks a window of a few cycles measured from the request. Stalled-ready runs compare only the order and values of the transfers, since their timing depends on the bench. `busy`/`inited` are read at the falling edge once `busy` has dropped.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {OP_NOP, OP_WR, OP_DAC} op_e;
  typedef enum logic [1:0] {M_UP, M_REINIT, M_DOWN} mode_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] addr;
    logic [7:0] data;
    logic [5:0] wait_ms;
    logic       last;
  } step_t;

  localparam int IDX_W = 5;
  localparam int MS_W  = 6;

  localparam logic [2:0] A_RES   = 3'd0;
  localparam logic [2:0] A_PHASE = 3'd1;
  localparam logic [2:0] A_PWRA  = 3'd3;
  localparam logic [2:0] A_PWRB  = 3'd4;
  localparam logic [2:0] A_PCTL  = 3'd6;
  localparam logic [2:0] A_POL   = 3'd7;

  localparam logic [IDX_W-1:0] STEP_PHASE = 5'd13;
  localparam logic [IDX_W-1:0] STEP_RES   = 5'd15;
  localparam logic [IDX_W-1:0] STEP_OFF   = 5'd16;

  localparam logic [MS_W-1:0] WAIT_VDD_MS  = 6'd3;
  localparam logic [MS_W-1:0] WAIT_GATE_MS = 6'd2;
  localparam logic [MS_W-1:0] WAIT_POL_MS  = 6'd1;
  localparam logic [MS_W-1:0] WAIT_OFF_MS  = 6'd34;

  localparam logic [7:0] VCOM_DEFAULT = 8'd125;
  localparam logic [7:0] PHASE_QVGA   = 8'h13;

  function automatic step_t mk(op_e o, logic [2:0] a, logic [7:0] d,
                               logic [MS_W-1:0] w, logic l);
    step_t s;
    s.op = o; s.addr = a; s.data = d; s.wait_ms = w; s.last = l;
    return s;
  endfunction
endpackage

// File: rtl/lps_ms_timer.sv
module lps_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int MS_W       = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms,
  output logic            expired,
  output logic            running
);
  logic [MS_W-1:0] ms_left;
  logic            tick_end;

  generate
    if (CYC_PER_MS > 1) begin : g_pre
      localparam int PRE_W = $clog2(CYC_PER_MS);
      logic [PRE_W-1:0] pre_cnt;
      assign tick_end = (pre_cnt == PRE_W'(CYC_PER_MS - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    pre_cnt <= '0;
        else if (start || tick_end)    pre_cnt <= '0;
        else if (running)              pre_cnt <= pre_cnt + 1'b1;
      end
    end else begin : g_nopre
      assign tick_end = 1'b1;
    end
  endgenerate

  assign expired = running && tick_end && (ms_left == MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ms_left <= '0;
    end else if (start) begin
      running <= 1'b1;
      ms_left <= ms;
    end else if (running && tick_end) begin
      if (ms_left == MS_W'(1)) running <= 1'b0;
      else                     ms_left <= ms_left - 1'b1;
    end
  end

  assert_ms_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (ms_left != '0));
  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
endmodule

// File: rtl/lps_step_table.sv
module lps_step_table
  import lps_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       phase_byte,
  input  logic             res_qvga,
  input  logic [7:0]       vcom_code,
  output step_t            step
);
  always_comb begin
    case (idx)
      5'd0:  step = mk(OP_WR,  A_PCTL,  8'h1F, '0, 1'b0);
      5'd1:  step = mk(OP_WR,  A_PWRA,  8'h03, '0, 1'b0);
      5'd2:  step = mk(OP_WR,  A_PWRB,  8'h00, '0, 1'b0);
      5'd3:  step = mk(OP_WR,  A_PWRB,  8'h04, WAIT_VDD_MS, 1'b0);
      5'd4:  step = mk(OP_WR,  A_PWRA,  8'h07, '0, 1'b0);
      5'd5:  step = mk(OP_WR,  A_PCTL,  8'h09, '0, 1'b0);
      5'd6:  step = mk(OP_DAC, 3'd0,    vcom_code, '0, 1'b0);
      5'd7:  step = mk(OP_WR,  A_PWRA,  8'h17, '0, 1'b0);
      5'd8:  step = mk(OP_WR,  A_PWRB,  8'h06, WAIT_GATE_MS, 1'b0);
      5'd9:  step = mk(OP_WR,  A_PCTL,  8'h01, '0, 1'b0);
      5'd10: step = mk(OP_WR,  A_PWRA,  8'h1F, '0, 1'b0);
      5'd11: step = mk(OP_WR,  A_PWRB,  8'h07, '0, 1'b0);
      5'd12: step = mk(OP_WR,  A_PCTL,  8'h00, '0, 1'b0);
      5'd13: step = mk(OP_WR,  A_PHASE, phase_byte, '0, 1'b0);
      5'd14: step = mk(OP_WR,  A_POL,   8'h00, WAIT_POL_MS, 1'b0);
      5'd15: step = mk(OP_WR,  A_RES,   {7'd0, res_qvga}, '0, 1'b1);
      5'd16: step = mk(OP_NOP, 3'd0,    8'h00, WAIT_OFF_MS, 1'b0);
      5'd17: step = mk(OP_WR,  A_PWRB,  8'h06, '0, 1'b0);
      5'd18: step = mk(OP_WR,  A_PCTL,  8'h08, '0, 1'b0);
      5'd19: step = mk(OP_WR,  A_PWRA,  8'h14, '0, 1'b0);
      5'd20: step = mk(OP_DAC, 3'd0,    8'h00, '0, 1'b0);
      5'd21: step = mk(OP_WR,  A_PWRB,  8'h04, '0, 1'b0);
      5'd22: step = mk(OP_WR,  A_PWRA,  8'h10, '0, 1'b0);
      5'd23: step = mk(OP_WR,  A_PCTL,  8'h1E, '0, 1'b0);
      5'd24: step = mk(OP_WR,  A_PWRA,  8'h00, '0, 1'b0);
      5'd25: step = mk(OP_WR,  A_PWRB,  8'h00, '0, 1'b1);
      default: step = mk(OP_NOP, 3'd0,  8'h00, '0, 1'b1);
    endcase
  end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lps_pkg::*;
#(
  parameter int CYC_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       pwr_off_req,
  input  logic       res_qvga,
  input  logic [3:0] phase_val,
  input  logic       phase_vld,
  input  logic [7:0] vcom_val,
  input  logic       vcom_vld,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [2:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       dac_valid,
  input  logic       dac_ready,
  output logic [7:0] dac_code,
  output logic       busy,
  output logic       inited
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e           state_q;
  mode_e            mode_q;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic [7:0]       phase_q, vcom_q;
  logic             res_q;
  step_t            cur;
  logic             step_done, seq_end, tmr_start, tmr_exp, tmr_run;

  lps_step_table u_table (
    .idx(idx_q), .phase_byte(phase_q), .res_qvga(res_q),
    .vcom_code(vcom_q), .step(cur)
  );

  lps_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .ms(cur.wait_ms),
    .expired(tmr_exp), .running(tmr_run)
  );

  assign busy      = (state_q != S_IDLE);
  assign wr_valid  = (state_q == S_ISSUE) && (cur.op == OP_WR);
  assign dac_valid = (state_q == S_ISSUE) && (cur.op == OP_DAC);
  assign wr_addr   = cur.addr;
  assign wr_data   = cur.data;
  assign dac_code  = cur.data;

  always_comb begin
    case (cur.op)
      OP_WR:   step_done = wr_ready;
      OP_DAC:  step_done = dac_ready;
      default: step_done = 1'b1;
    endcase
    step_done = step_done && (state_q == S_ISSUE);
  end

  assign tmr_start = step_done && (cur.wait_ms != '0);
  assign seq_end   = cur.last || ((mode_q == M_REINIT) && (idx_q == STEP_RES));
  assign nxt_idx   = ((mode_q == M_REINIT) && (idx_q == STEP_PHASE)) ? STEP_RES
                                                                      : idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= M_UP;
      idx_q   <= '0;
      phase_q <= '0;
      vcom_q  <= '0;
      res_q   <= 1'b0;
      inited  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (pwr_off_req) begin
            mode_q  <= M_DOWN;
            idx_q   <= STEP_OFF;
            state_q <= S_ISSUE;
          end else if (pwr_on_req) begin
            res_q   <= res_qvga;
            vcom_q  <= vcom_vld ? vcom_val : VCOM_DEFAULT;
            phase_q <= res_qvga ? PHASE_QVGA
                     : (phase_vld ? {3'd0, phase_val, 1'b1} : 8'h01);
            mode_q  <= inited ? M_REINIT : M_UP;
            idx_q   <= inited ? STEP_PHASE : '0;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE, S_WAIT: begin
          if ((state_q == S_ISSUE && step_done && cur.wait_ms != '0)) begin
            state_q <= S_WAIT;
          end else if ((state_q == S_ISSUE && step_done) ||
                       (state_q == S_WAIT && tmr_exp)) begin
            if (seq_end) begin
              state_q <= S_IDLE;
              inited  <= (mode_q != M_DOWN);
            end else begin
              idx_q   <= nxt_idx;
              state_q <= S_ISSUE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && !dac_ready) |=> (dac_valid && $stable(dac_code)));
  assert_paths_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && dac_valid));
  assert_reinit_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_REINIT && wr_valid) |-> (wr_addr == A_PHASE || wr_addr == A_RES));
  assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mode_q == M_DOWN) |-> !inited);
  assert_wait_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) |-> tmr_run);
endmodule

// File: tb/lcd_pwr_seq_tb_top.sv
module lcd_pwr_seq_tb_top;
  localparam int C = 20;

  logic clk = 0, rst_n = 0;
  logic pwr_on_req = 0, pwr_off_req = 0, res_qvga = 0, phase_vld = 0, vcom_vld = 0;
  logic [3:0] phase_val = 0;
  logic [7:0] vcom_val = 0;
  logic wr_ready = 1, dac_ready = 1;
  logic wr_valid, dac_valid, busy, inited;
  logic [2:0] wr_addr;
  logic [7:0] wr_data, dac_code;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit stall = 0;
  int l_val[0:63], l_t[0:63], l_n = 0;
  int e_val[0:63], e_n = 0;

  always #10 clk = ~clk;

  lcd_pwr_seq #(.CYC_PER_MS(C)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .res_qvga(res_qvga), .phase_val(phase_val), .phase_vld(phase_vld),
    .vcom_val(vcom_val), .vcom_vld(vcom_vld), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .dac_valid(dac_valid), .dac_ready(dac_ready),
    .dac_code(dac_code), .busy(busy), .inited(inited)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    wr_ready  <= stall ? (cyc % 3 == 2) : 1'b1;
    dac_ready <= stall ? (cyc % 4 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (l_n < 64 && wr_valid && wr_ready) begin
      l_val[l_n] = 256 * wr_addr + wr_data; l_t[l_n] = cyc; l_n = l_n + 1;
    end else if (l_n < 64 && dac_valid && dac_ready) begin
      l_val[l_n] = 4096 + dac_code; l_t[l_n] = cyc; l_n = l_n + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic pw(int a, int d); e_val[e_n] = 256 * a + d; e_n++; endtask
  task automatic pd(int d); e_val[e_n] = 4096 + d; e_n++; endtask

  task automatic exp_up(int ph, int vc, int res);
    e_n = 0;
    pw(6,'h1F); pw(3,'h03); pw(4,'h00); pw(4,'h04); pw(3,'h07); pw(6,'h09);
    pd(vc); pw(3,'h17); pw(4,'h06); pw(6,'h01); pw(3,'h1F); pw(4,'h07);
    pw(6,'h00); pw(1,ph); pw(7,'h00); pw(0,res);
  endtask

  task automatic exp_off();
    e_n = 0;
    pw(4,'h06); pw(6,'h08); pw(3,'h14); pd(0); pw(4,'h04); pw(3,'h10);
    pw(6,'h1E); pw(3,'h00); pw(4,'h00);
  endtask

  task automatic cmp_log(string req);
    chk(l_n == e_n, req, l_n, e_n);
    for (int i = 0; i < e_n && i < l_n; i++) chk(l_val[i] == e_val[i], req, l_val[i], e_val[i]);
  endtask

  task automatic pulse(bit on, bit off);
    @(posedge clk); #1; pwr_on_req = on; pwr_off_req = off;
    @(posedge clk); #1; pwr_on_req = 0; pwr_off_req = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    @(negedge clk);
    while (busy && k < 5000) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!wr_valid && !dac_valid, "R1 valids", {wr_valid, dac_valid}, 0);
    chk(!busy && !inited, "R1 busy/inited", {busy, inited}, 0);
  endtask

  task automatic t_cold_vga();
    l_n = 0; res_qvga = 0; phase_val = 4'd5; phase_vld = 1; vcom_val = 8'h60; vcom_vld = 1;
    pulse(1, 0);
    res_qvga = 1; phase_val = 4'd2; vcom_val = 8'h11;   // R12: after capture
    repeat (30) @(posedge clk);
    pulse(0, 1);                                        // R10: ignored while busy
    pulse(1, 0);
    wait_idle();
    exp_up('h0B, 'h60, 0);
    cmp_log("R3/R5/R6/R7/R10/R12 cold VGA");
    chk(inited == 1, "R3 inited", inited, 1);
    chk(l_t[4] - l_t[3] == 3*C + 1, "R4 vdd wait", l_t[4] - l_t[3], 3*C + 1);
    chk(l_t[9] - l_t[8] == 2*C + 1, "R4 gate wait", l_t[9] - l_t[8], 2*C + 1);
    chk(l_t[15] - l_t[14] == C + 1, "R4 pol wait", l_t[15] - l_t[14], C + 1);
    chk(l_t[1] - l_t[0] == 1, "R4 no wait", l_t[1] - l_t[0], 1);
    chk(l_t[6] - l_t[5] == 1, "R5 dac timing", l_t[6] - l_t[5], 1);
  endtask

  task automatic t_reinit(bit q, bit pv, int ph, int exp_ph, string req);
    l_n = 0; res_qvga = q; phase_vld = pv; phase_val = ph[3:0];
    pulse(1, 0);
    wait_idle();
    e_n = 0; pw(1, exp_ph); pw(0, q ? 1 : 0);
    cmp_log(req);
    chk(l_n < 2 || l_t[1] - l_t[0] == 1, "R8 no wait", l_n < 2 ? 0 : l_t[1] - l_t[0], 1);
    chk(inited == 1, "R8 inited kept", inited, 1);
  endtask

  task automatic t_off(bit both);
    int t_req;
    l_n = 0;
    t_req = cyc;
    pulse(both, 1);
    wait_idle();
    exp_off();
    cmp_log(both ? "R11 both requests" : "R9 off sequence");
    chk(l_t[0] - t_req >= 34*C && l_t[0] - t_req <= 34*C + 4, "R9 pre-wait",
        l_t[0] - t_req, 34*C + 2);
    chk(inited == 0, "R9 inited cleared", inited, 0);
  endtask

  task automatic t_cold_qvga_stall();
    l_n = 0; stall = 1; res_qvga = 1; phase_vld = 1; phase_val = 4'd3; vcom_vld = 0;
    pulse(1, 0);
    wait_idle();
    stall = 0;
    exp_up('h13, 125, 1);
    cmp_log("R2/R5/R6/R7 QVGA stalled, default bias");
    chk(inited == 1, "R3 inited qvga", inited, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_cold_vga();
    t_reinit(1, 1, 7, 'h13, "R8/R6 reinit QVGA");
    t_reinit(0, 0, 7, 'h01, "R8/R6 reinit VGA no phase");
    t_reinit(0, 1, 15, 'h1F, "R8/R6 reinit VGA phase 15");
    t_off(0);
    t_cold_qvga_stall();
    t_off(1);
    finish_run();
  end
endmodule